// File: doc/BRIEF.md
# Clause 22 Management Data Master

This block is a register-driven master for the two-wire PHY management bus of IEEE 802.3 Clause 22. A host writes a command word that holds a read flag, a 5-bit PHY address and a 5-bit register address. A read launches as soon as a command with the read flag set is written. A write needs two steps. First a command with the read flag clear is written, which arms the write. The next write to the data register then supplies the 16-bit payload and launches the frame.

The block derives the management clock (MDC) from the host clock with a programmable divider. It drives the data line through an output and an output-enable pair, and samples the line through a separate input. Each frame is 64 bit-times long: 32 preamble ones, a start pair, an opcode pair, the PHY address, the register address, a two-bit turnaround and 16 data bits. A status word shows the divider, a BUSY flag that covers the whole frame, and a sticky read-error flag. The read-error flag is set when the PHY leaves the second turnaround bit high.

Register offsets on `reg_addr`:
- 0 is the command word: bit 15 is the read flag, bits 12:8 are the PHY address and bits 4:0 are the register address.
- 1 is the data word, in bits 15:0.
- 2 is the status word: bits 7:0 are the divider, bit 16 is BUSY (read only) and bit 17 is the read error (write 1 to clear).
- 3 reads as zero.

`DIV_W` must not exceed 16.

Top module: `mdio_master`

## Requirements
- R1: While a frame runs, MDC has a period of 2×divider host cycles, with the low phase first. While idle, MDC is held low.
- R2: The divider is status bits 7:0 and resets to `DIV_RESET`. A status write whose divider field is below `DIV_MIN` leaves the divider unchanged.
- R3: Writing the command word (offset 0) with bit 15 set starts a read. BUSY (status bit 16) is high in the very next cycle.
- R4: Writing the command word with bit 15 clear arms a write. The next write to the data word (offset 1) starts the frame. A data write that no armed command precedes only stores the value and starts nothing.
- R5: BUSY stays high for exactly 128×divider host cycles per frame.
- R6: The frame bits, in order, are:
  - 32 ones;
  - 0 then 1;
  - the opcode: 1,0 for a read and 0,1 for a write;
  - the PHY address, MSB first;
  - the register address, MSB first;
  - for a write, the turnaround 1,0 and then the 16 data bits, MSB first.
- R7: The master changes its MDIO output only while MDC is low, so every bit is stable when MDC rises.
- R8: In a read, the output enable drops for the last 18 bit-times, which are both turnaround bits and the 16 data bits.
- R9: After a read, the data word holds the 16 bits sampled on the MDC rising edges, MSB first, in bits 15:0, with bits 31:16 zero.
- R10: Status bit 17 is set when the line is high at the rising edge of the second turnaround bit of a read. It stays set through later reads and clears only when the status word is written with bit 17 set.
- R11: While BUSY is high, writes to every register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line sampled value |

## Verification
The assertions assume the host changes nothing while a frame is in flight. The divider is therefore constant across a frame, which the 128×divider length check relies on. They also assume `mdio_i` is settled well before each MDC rising edge. The stimulus programs the divider only while the block is idle and always at or above the minimum. It drives the PHY model's response on the falling MDC edge, so the line is at least one divider-length low phase old when it is sampled. The busy-time writes of R11 are aimed at the register state and are checked by reading back afterwards.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int FRAME_BITS = 64;
  localparam int IDX_W      = 6;
  localparam int TA_FIRST   = 46;
  localparam int TA_SECOND  = 47;
  localparam int DATA_FIRST = 48;
  localparam int LAST_BIT   = FRAME_BITS - 1;

  localparam int CMD_RD_BIT   = 15;
  localparam int CMD_PHY_LSB  = 8;
  localparam int CMD_REG_LSB  = 0;
  localparam int STAT_BSY_BIT = 16;
  localparam int STAT_ERR_BIT = 17;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_DATA = 2'd1,
    SEL_STAT = 2'd2,
    SEL_RSVD = 2'd3
  } sel_e;

  typedef struct packed {
    logic       rd;
    logic [4:0] phy;
    logic [4:0] regad;
  } cmd_t;

  // Serial image of one frame, transmitted from bit 63 downward.
  function automatic logic [FRAME_BITS-1:0] frame_bits(cmd_t c, logic [15:0] d);
    logic [1:0] op;
    logic [1:0] ta;
    op = c.rd ? 2'b10 : 2'b01;
    ta = c.rd ? 2'b11 : 2'b10;
    return {32'hFFFF_FFFF, 2'b01, op, c.phy, c.regad, ta, c.rd ? 16'hFFFF : d};
  endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             last;

  assign last = (cnt_q == (div - ONE));

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (last) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = run & last & ~mdc_q;
  assign fall_stb = run & last &  mdc_q;

  // R1: clock parks low whenever no frame runs
  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc_q);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        launch,
  input  cmd_t        l_cmd,
  input  logic [15:0] l_data,
  input  logic        rise_stb,
  input  logic        fall_stb,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_done,
  output logic        rd_err_set,
  output logic [15:0] rd_data
);

  localparam logic [IDX_W-1:0] IDX_TA1  = IDX_W'(TA_FIRST);
  localparam logic [IDX_W-1:0] IDX_TA2  = IDX_W'(TA_SECOND);
  localparam logic [IDX_W-1:0] IDX_DAT  = IDX_W'(DATA_FIRST);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(LAST_BIT);
  localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

  logic                  busy_q, busy_d;
  logic                  rd_q, rd_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [15:0]           rdsh_q, rdsh_d;
  logic                  done;

  always_comb begin
    busy_d     = busy_q;
    rd_d       = rd_q;
    sh_d       = sh_q;
    idx_d      = idx_q;
    rdsh_d     = rdsh_q;
    done       = 1'b0;
    rd_err_set = 1'b0;
    if (launch) begin
      busy_d = 1'b1;
      rd_d   = l_cmd.rd;
      sh_d   = frame_bits(l_cmd, l_data);
      idx_d  = '0;
      rdsh_d = '0;
    end else if (busy_q) begin
      if (rise_stb) begin
        if (rd_q && (idx_q >= IDX_DAT))
          rdsh_d = {rdsh_q[14:0], mdio_i};
        if (rd_q && (idx_q == IDX_TA2) && mdio_i)
          rd_err_set = 1'b1;
      end
      if (fall_stb) begin
        if (idx_q == IDX_LAST) begin
          busy_d = 1'b0;
          done   = 1'b1;
        end else begin
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
          idx_d = idx_q + IDX_ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      sh_q   <= '0;
      idx_q  <= '0;
      rdsh_q <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      rdsh_q <= rdsh_d;
    end
  end

  assign busy    = busy_q;
  assign mdio_o  = sh_q[FRAME_BITS-1];
  assign mdio_oe = busy_q & ~(rd_q & (idx_q >= IDX_TA1));
  assign rd_done = done & rd_q;
  assign rd_data = rdsh_q;

  // R3: any accepted launch shows as busy on the next cycle
  a_r3_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> busy_q);

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_MIN   = 2,
  parameter int DIV_RESET = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_addr,
  input  logic             reg_we,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             busy,
  input  logic             rd_done,
  input  logic             rd_err_set,
  input  logic [15:0]      rd_data,
  output logic             launch,
  output cmd_t             l_cmd,
  output logic [15:0]      l_data,
  output logic [DIV_W-1:0] div
);

  localparam logic [DIV_W-1:0] DIV_MIN_V = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] DIV_RST_V = DIV_W'(DIV_RESET);

  sel_e             sel;
  cmd_t             wcmd;
  logic             wr_ok;
  cmd_t             cmd_q, cmd_d;
  logic [15:0]      data_q, data_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             err_q, err_d;
  logic             armed_q, armed_d;
  logic             unused_wdata;

  assign sel          = sel_e'(reg_addr);
  assign wr_ok        = reg_we & ~busy;
  assign wcmd         = '{rd:    reg_wdata[CMD_RD_BIT],
                          phy:   reg_wdata[CMD_PHY_LSB +: 5],
                          regad: reg_wdata[CMD_REG_LSB +: 5]};
  assign unused_wdata = ^reg_wdata;

  always_comb begin
    cmd_d   = cmd_q;
    data_d  = data_q;
    div_d   = div_q;
    err_d   = err_q;
    armed_d = armed_q;
    if (wr_ok) begin
      case (sel)
        SEL_CMD: begin
          cmd_d   = wcmd;
          armed_d = ~wcmd.rd;
        end
        SEL_DATA: begin
          data_d  = reg_wdata[15:0];
          armed_d = 1'b0;
        end
        SEL_STAT: begin
          if (reg_wdata[DIV_W-1:0] >= DIV_MIN_V)
            div_d = reg_wdata[DIV_W-1:0];
          if (reg_wdata[STAT_ERR_BIT])
            err_d = 1'b0;
        end
        default: ;
      endcase
    end
    if (rd_done)    data_d = rd_data;
    if (rd_err_set) err_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      data_q  <= '0;
      div_q   <= DIV_RST_V;
      err_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cmd_q   <= cmd_d;
      data_q  <= data_d;
      div_q   <= div_d;
      err_q   <= err_d;
      armed_q <= armed_d;
    end
  end

  // A read starts from the command alone; a write from the data word after an armed command.
  always_comb begin
    launch = 1'b0;
    l_cmd  = cmd_q;
    l_data = reg_wdata[15:0];
    if (wr_ok && (sel == SEL_CMD) && wcmd.rd) begin
      launch = 1'b1;
      l_cmd  = wcmd;
    end else if (wr_ok && (sel == SEL_DATA) && armed_q) begin
      launch = 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_CMD: begin
        reg_rdata[CMD_RD_BIT]         = cmd_q.rd;
        reg_rdata[CMD_PHY_LSB +: 5]   = cmd_q.phy;
        reg_rdata[CMD_REG_LSB +: 5]   = cmd_q.regad;
      end
      SEL_DATA: reg_rdata[15:0] = data_q;
      SEL_STAT: begin
        reg_rdata[DIV_W-1:0]   = div_q;
        reg_rdata[STAT_BSY_BIT] = busy;
        reg_rdata[STAT_ERR_BIT] = err_q;
      end
      default: ;
    endcase
  end

  assign div = div_q;

  // R2: divider never below the legal floor
  a_r2_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
    div_q >= DIV_MIN_V);

  // R11: host writes during a frame leave configuration untouched
  a_r11_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we) |=> ($stable(div_q) && $stable(cmd_q)));

  // R10: error flag holds until explicitly cleared
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !(wr_ok && (sel == SEL_STAT) && reg_wdata[STAT_ERR_BIT])) |=> err_q);

  // R4: unarmed data write starts nothing
  a_r4_data_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && (sel == SEL_DATA) && !armed_q) |=> !busy);

endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int DIV_MIN   = 2,
  parameter int DIV_RESET = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);

  localparam int BLEN_W = DIV_W + 8;

  logic             busy;
  logic             launch;
  cmd_t             l_cmd;
  logic [15:0]      l_data;
  logic [DIV_W-1:0] div;
  logic             rise_stb;
  logic             fall_stb;
  logic             rd_done;
  logic             rd_err_set;
  logic [15:0]      rd_data;

  mdio_regs #(
    .DIV_W    (DIV_W),
    .DIV_MIN  (DIV_MIN),
    .DIV_RESET(DIV_RESET)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .rd_done   (rd_done),
    .rd_err_set(rd_err_set),
    .rd_data   (rd_data),
    .launch    (launch),
    .l_cmd     (l_cmd),
    .l_data    (l_data),
    .div       (div)
  );

  mdio_clk_gen #(
    .DIV_W(DIV_W)
  ) u_clk_gen (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (busy),
    .div     (div),
    .mdc     (mdc),
    .rise_stb(rise_stb),
    .fall_stb(fall_stb)
  );

  mdio_frame_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .launch    (launch),
    .l_cmd     (l_cmd),
    .l_data    (l_data),
    .rise_stb  (rise_stb),
    .fall_stb  (fall_stb),
    .mdio_i    (mdio_i),
    .busy      (busy),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .rd_done   (rd_done),
    .rd_err_set(rd_err_set),
    .rd_data   (rd_data)
  );

  // Checker counter: host cycles spent busy in the current frame.
  logic [BLEN_W-1:0] blen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     blen_q <= '0;
    else if (!busy) blen_q <= '0;
    else            blen_q <= blen_q + BLEN_W'(1);
  end

  // R5: a frame occupies 128 x divider host cycles
  a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen_q == {1'b0, div, 7'b0}));

  // R7: output bit moves only during the MDC low phase
  a_r7_mdio_on_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mdio_o != $past(mdio_o))) |-> !mdc);

endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;
  localparam int DIV_RESET  = 4;

  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_DATA = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  // {rd, phy[4:0], reg[4:0], data[15:0], div[7:0], ta_bad}
  localparam int NVEC = 5;
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b0, 5'h01, 5'h00, 16'hA5C3, 8'd2, 1'b0},
    {1'b1, 5'h1F, 5'h1F, 16'h8001, 8'd3, 1'b0},
    {1'b0, 5'h10, 5'h0A, 16'hFFFF, 8'd4, 1'b0},
    {1'b1, 5'h00, 5'h02, 16'h0000, 8'd2, 1'b0},
    {1'b1, 5'h03, 5'h11, 16'h1234, 8'd5, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  reg_addr;
  logic        reg_we;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc;
  logic        mdio_o;
  logic        mdio_oe;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_master u_mdio_master (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_addr (reg_addr),
    .reg_we   (reg_we),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .mdio_i   (mdio_i)
  );

  // Cycle count and output-change watcher (R7)
  int   cyc = 0;
  int   chg_bad = 0;
  logic prev_o = 1'b0;
  logic prev_oe = 1'b0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n && mdio_oe && prev_oe && (mdio_o != prev_o) && mdc)
      chg_bad = chg_bad + 1;
    prev_o  = mdio_o;
    prev_oe = mdio_oe;
  end

  // PHY model: captures on rising MDC, answers on falling MDC
  logic [63:0] cap_o  = '0;
  logic [63:0] cap_oe = '0;
  int          frame_pos = 0;
  int          prev_rise = 0;
  int          last_period = 0;
  logic [15:0] phy_rdata = 16'h0;
  logic        phy_ta_bad = 1'b0;

  always @(posedge mdc) begin
    cap_o       = {cap_o[62:0], mdio_o};
    cap_oe      = {cap_oe[62:0], mdio_oe};
    frame_pos   = (frame_pos + 1) % 64;
    last_period = cyc - prev_rise;
    prev_rise   = cyc;
  end

  always @(negedge mdc) begin
    if (frame_pos == 47)      mdio_i = phy_ta_bad;
    else if (frame_pos >= 48) mdio_i = phy_rdata[63 - frame_pos];
    else                      mdio_i = 1'b1;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    @(posedge clk);
    #1 reg_we = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    rdreg(A_STAT, v);
    while (v[16]) begin
      n = n + 1;
      rdreg(A_STAT, v);
    end
  endtask

  function automatic logic [31:0] cmd_word(input logic rd, input logic [4:0] phy,
                                           input logic [4:0] ra);
    return {16'h0, rd, 2'b00, phy, 3'b000, ra};
  endfunction

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] phy,
                                            input logic [4:0] ra, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra, 2'b10, d};
  endfunction

  task automatic run_frame(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] d, output int n);
    if (rd) begin
      wr(A_CMD, cmd_word(1'b1, phy, ra));
    end else begin
      wr(A_CMD, cmd_word(1'b0, phy, ra));
      wr(A_DATA, {16'h0, d});
    end
    wait_idle(n);
  endtask

  task automatic run_all();
    logic [31:0] v;
    int          n;
    logic [63:0] ef;

    rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    rdreg(A_STAT, v); chk("R2 reset divider, busy and error", 64'(v), 64'(DIV_RESET));
    rdreg(A_CMD, v);  chk("R3 reset command word", 64'(v), 64'h0);
    rdreg(A_DATA, v); chk("R9 reset data word", 64'(v), 64'h0);
    chk("R1 MDC low after reset", 64'(mdc), 64'h0);
    chk("R8 output enable low after reset", 64'(mdio_oe), 64'h0);

    // Divider floor
    wr(A_STAT, 32'd3); rdreg(A_STAT, v); chk("R2 legal divider taken", 64'(v[7:0]), 64'd3);
    wr(A_STAT, 32'd1); rdreg(A_STAT, v); chk("R2 divider 1 ignored", 64'(v[7:0]), 64'd3);
    wr(A_STAT, 32'd0); rdreg(A_STAT, v); chk("R2 divider 0 ignored", 64'(v[7:0]), 64'd3);

    // Unarmed data write
    wr(A_DATA, 32'h0000_5A5A);
    repeat (5) @(negedge clk);
    rdreg(A_STAT, v); chk("R4 unarmed data write stays idle", 64'(v[16]), 64'h0);
    chk("R4 MDC quiet after unarmed write", 64'(mdc), 64'h0);
    rdreg(A_DATA, v); chk("R4 unarmed data stored", 64'(v), 64'h5A5A);

    // Vector table
    for (int i = 0; i < NVEC; i++) begin
      logic        vrd;
      logic [4:0]  vphy;
      logic [4:0]  vra;
      logic [15:0] vd;
      logic [7:0]  vdiv;
      logic        vta;
      {vrd, vphy, vra, vd, vdiv, vta} = VEC[i];
      wr(A_STAT, 32'h0002_0000 | 32'(vdiv));
      phy_rdata  = vd;
      phy_ta_bad = vta;
      run_frame(vrd, vphy, vra, vd, n);
      chk(vrd ? "R3 read launched" : "R4 armed write launched", 64'(n != 0), 64'h1);
      chk("R5 busy length", 64'(n), 64'(128 * vdiv));
      chk("R1 MDC period", 64'(last_period), 64'(2 * vdiv));
      ef = exp_frame(vrd, vphy, vra, vd);
      if (vrd) begin
        chk("R6 R7 read frame header", 64'(cap_o[63:18]), 64'(ef[63:18]));
        chk("R8 read release window", cap_oe, {{46{1'b1}}, 18'h0});
        rdreg(A_DATA, v); chk("R9 read data", 64'(v), 64'(vd));
        rdreg(A_STAT, v); chk("R10 error bit after read", 64'(v[17]), 64'(vta));
      end else begin
        chk("R6 R7 write frame", cap_o, ef);
        chk("R8 write drives all bits", cap_oe, {64{1'b1}});
      end
    end

    // Sticky error: bad-TA read leaves it set, a good read does not clear it
    phy_ta_bad = 1'b0;
    phy_rdata  = 16'hBEEF;
    run_frame(1'b1, 5'h04, 5'h05, 16'h0, n);
    rdreg(A_STAT, v); chk("R10 error sticky across good read", 64'(v[17]), 64'h1);
    rdreg(A_DATA, v); chk("R9 good read data", 64'(v), 64'hBEEF);
    wr(A_STAT, 32'h0002_0002);
    rdreg(A_STAT, v); chk("R10 write-one clears error", 64'(v), 64'h2);

    // Writes while busy
    wr(A_CMD, cmd_word(1'b0, 5'h02, 5'h03));
    wr(A_DATA, 32'h0000_1111);
    wr(A_STAT, 32'd9);
    wr(A_DATA, 32'h0000_2222);
    wr(A_CMD, cmd_word(1'b1, 5'h1E, 5'h1D));
    wait_idle(n);
    rdreg(A_STAT, v); chk("R11 divider unchanged by busy write", 64'(v[7:0]), 64'd2);
    rdreg(A_DATA, v); chk("R11 data unchanged by busy write", 64'(v), 64'h1111);
    rdreg(A_CMD, v);  chk("R11 command unchanged by busy write", 64'(v),
                          64'(cmd_word(1'b0, 5'h02, 5'h03)));
    chk("R6 R7 frame after busy writes", cap_o, exp_frame(1'b0, 5'h02, 5'h03, 16'h1111));

    chk("R7 output changes only with MDC low", 64'(chg_bad), 64'h0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks = checks + 1;
        fails  = fails + 1;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule